// File: doc/BRIEF.md
# Pipelined Three-Lane Dot-Product Chain

This block computes a signed dot product of length three on a chain of three processing elements. A partial sum enters the first element, and each element adds the product of its own operand pair before passing the running total on to the next. Inside every element the multiplier and the adder sit in separate register stages. The product is captured in one clock and accumulated in the next, so the longest combinational path is a single multiply or a single add, never both in series.

To keep each operand pair aligned with the running sum, the pair for element n is held back n clocks before it reaches its multiplier. A valid flag follows the data through a shift register of the same depth. A new sample can be presented on every clock, and its result appears four clocks later.

Top module: `dot3_chain`

## Requirements
- R1: While reset is low, and on the first clock after it is released, `out_valid` is 0 and `out_sum` is 0.
- R2: For a sample accepted with `in_valid` high, `out_sum` equals `c_in + a0*b0 + a1*b1 + a2*b2`. Every term is two's complement signed. Lane n of `op_a` and `op_b` occupies bits [8n+7:8n].
- R3: `out_valid` rises exactly 4 clocks after the edge that sampled `in_valid` high. It stays low for every clock whose sample had `in_valid` low.
- R4: A new sample is accepted on every clock. Back-to-back samples each produce their own correct result, in the order they were accepted, with no interference between samples in flight.
- R5: A lane whose `a` or whose `b` operand is zero adds nothing to the sum.
- R6: The sum is kept modulo 2^18 and wraps on overflow. The extreme products (-128 × -128 = 16384) are exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample on the inputs is to be processed |
| c_in | input | 18 | Incoming partial sum, signed |
| op_a | input | 24 | Three signed 8-bit `a` operands, lane n at bits [8n+7:8n] |
| op_b | input | 24 | Three signed 8-bit `b` operands, lane n at bits [8n+7:8n] |
| out_valid | output | 1 | `out_sum` holds a finished result |
| out_sum | output | 18 | Dot product plus partial sum, signed, modulo 2^18 |

## Verification
Two events can fall in the same clock. One element's adder can be folding in the product of one sample while its multiplier is already forming the product of the next sample, and the last element can be emitting a result while the first accepts a new one. Streams of samples on consecutive clocks, mixed with random idle gaps, provoke these overlaps. Each output is judged against the expected value of the sample that was accepted exactly four clocks earlier, so any slip in the operand skew or the valid pipe shows up as a wrong sum or a misplaced valid.

// File: rtl/dot3_pkg.sv
package dot3_pkg;
    localparam int OPERAND_W = 8;
    localparam int ACC_W     = 18;
    localparam int LANES     = 3;
endpackage

// File: rtl/dot3_skew.sv
module dot3_skew #(
    parameter int W     = 16,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_regs
            logic [DEPTH-1:0][W-1:0] sh_d, sh_q;

            always_comb begin
                sh_d[0] = din;
                for (int k = 1; k < DEPTH; k++) begin
                    sh_d[k] = sh_q[k-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end

            assign dout = sh_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/dot3_vpipe.sv
module dot3_vpipe #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);
    logic [DEPTH-1:0] vld_d, vld_q;

    always_comb begin
        vld_d[0] = vin;
        for (int k = 1; k < DEPTH; k++) begin
            vld_d[k] = vld_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    assign vout = vld_q[DEPTH-1];

    // R3: the first stage follows the accepted valid by one clock
    a_r3_entry_set: assert property (@(posedge clk) disable iff (!rst_n)
        vin |=> vld_q[0]);
    a_r3_entry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !vin |=> !vld_q[0]);

    generate
        for (genvar s = 0; s < DEPTH-1; s++) begin : g_chk
            // R3: each stage hands its flag on unchanged
            a_r3_stage_move: assert property (@(posedge clk) disable iff (!rst_n)
                vld_q[s] |=> vld_q[s+1]);
            a_r3_stage_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !vld_q[s] |=> !vld_q[s+1]);
        end
    endgenerate
endmodule

// File: rtl/dot3_pe.sv
module dot3_pe #(
    parameter int OP_W  = 8,
    parameter int SUM_W = 18,
    parameter int SKEW  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  a_in,
    input  logic [OP_W-1:0]  b_in,
    input  logic [SUM_W-1:0] sum_in,
    output logic [SUM_W-1:0] sum_out
);
    localparam int PROD_W = 2 * OP_W;
    localparam int EXT_W  = SUM_W - PROD_W;

    typedef struct packed {
        logic signed [PROD_W-1:0] prod;
        logic        [SUM_W-1:0]  acc;
    } pe_state_t;

    pe_state_t st_d, st_q;
    logic [PROD_W-1:0] pair_late;
    logic [OP_W-1:0]   mul_a, mul_b;

    dot3_skew #(.W(PROD_W), .DEPTH(SKEW)) u_skew (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({a_in, b_in}),
        .dout (pair_late)
    );

    assign mul_a = pair_late[PROD_W-1:OP_W];
    assign mul_b = pair_late[OP_W-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.prod = $signed(mul_a) * $signed(mul_b);
        st_d.acc  = sum_in + {{EXT_W{st_q.prod[PROD_W-1]}}, st_q.prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_out = st_q.acc;

    // R5: a zero operand leaves a zero product in the middle register
    a_r5_zero_product: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mul_a) == '0 || $past(mul_b) == '0) |-> st_q.prod == '0);
endmodule

// File: rtl/dot3_chain.sv
module dot3_chain
    import dot3_pkg::*;
#(
    parameter int OP_W  = OPERAND_W,
    parameter int SUM_W = ACC_W,
    parameter int N_PE  = LANES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [SUM_W-1:0]       c_in,
    input  logic [N_PE*OP_W-1:0]   op_a,
    input  logic [N_PE*OP_W-1:0]   op_b,
    output logic                   out_valid,
    output logic [SUM_W-1:0]       out_sum
);
    localparam int LAT = N_PE + 1;

    logic [N_PE:0][SUM_W-1:0] chain;

    // partial sum waits one clock so it meets the first product
    dot3_skew #(.W(SUM_W), .DEPTH(1)) u_cin_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (c_in),
        .dout (chain[0])
    );

    generate
        for (genvar p = 0; p < N_PE; p++) begin : g_pe
            dot3_pe #(.OP_W(OP_W), .SUM_W(SUM_W), .SKEW(p)) u_pe (
                .clk    (clk),
                .rst_n  (rst_n),
                .a_in   (op_a[p*OP_W +: OP_W]),
                .b_in   (op_b[p*OP_W +: OP_W]),
                .sum_in (chain[p]),
                .sum_out(chain[p+1])
            );
        end
    endgenerate

    dot3_vpipe #(.DEPTH(LAT)) u_vpipe (
        .clk  (clk),
        .rst_n(rst_n),
        .vin  (in_valid),
        .vout (out_valid)
    );

    assign out_sum = chain[N_PE];

    // ---------------- checking logic ----------------
    logic [SUM_W-1:0]          ref_now;
    logic [LAT-1:0][SUM_W-1:0] ref_q;

    always_comb begin
        ref_now = c_in;
        for (int p = 0; p < N_PE; p++) begin
            ref_now = ref_now + SUM_W'($signed(op_a[p*OP_W +: OP_W]) *
                                       $signed(op_b[p*OP_W +: OP_W]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= {ref_q[LAT-2:0], ref_now};
    end

    // R1: nothing is flagged right after reset is released
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R2: a flagged result matches the sample accepted LAT clocks before
    a_r2_sum_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum == ref_q[LAT-1]);
endmodule

// File: tb/dot3_chain_tb_top.sv
module dot3_chain_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;
    localparam int SLOTS      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] c_in = '0;
    logic [23:0] op_a = '0;
    logic [23:0] op_b = '0;
    logic        out_valid;
    logic [17:0] out_sum;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic        ev[SLOTS];
    logic [17:0] es[SLOTS];
    string       et[SLOTS];

    always #(CLK_PERIOD/2) clk = ~clk;

    dot3_chain dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .c_in     (c_in),
        .op_a     (op_a),
        .op_b     (op_b),
        .out_valid(out_valid),
        .out_sum  (out_sum)
    );

    function automatic logic [17:0] model(logic [17:0] c, logic [23:0] a, logic [23:0] b);
        int acc;
        acc = $signed(c);
        for (int k = 0; k < 3; k++) begin
            acc += $signed(a[8*k +: 8]) * $signed(b[8*k +: 8]);
        end
        return acc[17:0];
    endfunction

    task automatic check_out();
        int slot = cyc % SLOTS;
        checks++;
        if (out_valid !== ev[slot]) begin
            errors++;
            $display("FAIL R3 cycle %0d out_valid actual %b expected %b", cyc, out_valid, ev[slot]);
        end
        if (ev[slot]) begin
            checks++;
            if (out_sum !== es[slot]) begin
                errors++;
                $display("FAIL %s cycle %0d out_sum actual %0d expected %0d",
                         et[slot], cyc, $signed(out_sum), $signed(es[slot]));
            end
        end
        ev[slot] = 1'b0;
    endtask

    task automatic step(logic v, logic [17:0] c, logic [23:0] a, logic [23:0] b, string tag);
        int slot;
        @(negedge clk);
        check_out();
        in_valid = v;
        c_in = c;
        op_a = a;
        op_b = b;
        if (v) begin
            slot = (cyc + LAT) % SLOTS;
            ev[slot] = 1'b1;
            es[slot] = model(c, a, b);
            et[slot] = tag;
        end
        cyc++;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4217));
        for (int i = 0; i < SLOTS; i++) ev[i] = 1'b0;

        // R1: outputs quiet during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || out_sum !== 18'd0) begin
                errors++;
                $display("FAIL R1 reset out_valid %b sum %0d expected 0 0", out_valid, out_sum);
            end
        end
        rst_n = 1'b1;

        // R2: plain sample with small values
        step(1'b1, 18'd10, {8'd3, 8'd2, 8'd1}, {8'd4, 8'd5, 8'd6}, "R2");
        // R2: negative partial sum and mixed signs
        step(1'b1, -18'sd500, {8'hF0, 8'd7, 8'h81}, {8'd9, 8'hFD, 8'd100}, "R2");
        // R5: zero operands in every lane
        step(1'b1, 18'd5, {8'd0, 8'd77, 8'd0}, {8'hAA, 8'd0, 8'd0}, "R5");
        // R6: extreme products
        step(1'b1, 18'd0, {8'h80, 8'h80, 8'h80}, {8'h80, 8'h80, 8'h80}, "R6");
        // R6: positive overflow wraps
        step(1'b1, 18'h1FFFF, {8'd127, 8'd127, 8'd127}, {8'd127, 8'd127, 8'd127}, "R6");
        // R3: idle gaps stay quiet
        step(1'b0, 18'd1, 24'hFFFFFF, 24'hFFFFFF, "R3");
        step(1'b0, 18'd2, 24'h123456, 24'h654321, "R3");
        // R4: isolated sample then back-to-back burst
        step(1'b1, 18'd1, {8'd1, 8'd0, 8'd0}, {8'd1, 8'd0, 8'd0}, "R4");
        step(1'b0, 18'd0, 24'd0, 24'd0, "R3");
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 18'(i * 1000), {8'(i), 8'(2*i), 8'(3*i)}, {8'(-i), 8'(i), 8'(5)}, "R4");
        end

        // R4: random stream with random gaps, extremes mixed in
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 7) begin
                step(1'b1, 18'h20000, 24'h808080, 24'h7F7F7F, "R6");
            end else begin
                step(($urandom % 4) != 0, 18'($urandom), 24'($urandom), 24'($urandom), "R4");
            end
        end

        // drain the pipe
        for (int i = 0; i < LAT + 2; i++) begin
            step(1'b0, 18'd0, 24'd0, 24'd0, "R3");
        end
        finish_run();
    end
endmodule